// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block controls a single coin slot that takes two coin values: a small coin worth 5 units and a large coin worth 10 units. It keeps the deposited credit at one of four levels (0, 5, 10 or 15). Once the credit reaches 15 it raises a release output, which opens the delivery chute. It returns no change. A payment that would pass 15 is capped at 15, and the block stays at 15, with the release output held high, until reset clears the credit.

The credit is kept in one of two state encodings, chosen by a parameter. The first is a compact two-flop binary code. The second is a four-flop one-hot code, which decodes the release output from a single flop. Both encodings behave the same at the ports. Besides the release output decoded from state, the block has a second release output that sits in its own flop. That flop is loaded from the next-state logic, so it rises on the same clock edge at which the credit enters 15.

Top module: `coin_gate`

## Requirements
- R1: A synchronous active-high `rst` sets the credit to 0. Both release outputs are then 0 after the next rising clock edge. Reset takes priority over any coin presented in the same cycle.
- R2: A cycle with `nickel_i`=1 and `dime_i`=0 adds 5 to the credit. The steps are 0 to 5, 5 to 10 and 10 to 15.
- R3: A cycle with `dime_i`=1 adds 10 to the credit. The steps are 0 to 10, and 5 to 15. From 10 the credit goes to 15, and the excess is absorbed.
- R4: A cycle with both `nickel_i` and `dime_i` set to 1 counts as one large coin only (+10).
- R5: A cycle with neither coin input set leaves the credit unchanged.
- R6: `release_o` is 1 exactly while the credit is 15. It is registered state, so it changes only at a clock edge after a coin.
- R7: Once the credit is 15, it stays at 15 and both release outputs stay at 1 until reset. Coins arriving in this state have no effect.
- R8: `release_reg_o` is a flop loaded with the next-state release value. It rises on the same edge at which the credit enters 15, so it equals `release_o` in every cycle.
- R9: With `ONEHOT`=0 the state is two flops: 0=00, 5=01, 10=10, 15=11. With `ONEHOT`=1 the state is four flops, one per level: bit0 for 0, bit1 for 5, bit2 for 10, bit3 for 15. Exactly one bit is set outside reset. The port behaviour is identical in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears the credit |
| nickel_i | input | 1 | One-cycle pulse: a 5-unit coin was accepted |
| dime_i | input | 1 | One-cycle pulse: a 10-unit coin was accepted |
| release_o | output | 1 | Release chute, decoded from the credit state |
| release_reg_o | output | 1 | Release chute, registered from the next-state logic |

## Verification
Coin sequences that reach exactly 15 are applied in several orders (three small coins, small then large, large then small). Each must open on the final coin and not before, which tells the per-coin step sizes apart. Two large coins and a large coin at 10 show that overpayment is capped. A combined pulse followed by a small coin opens only if the combined pulse was taken as a large coin. Coin pulses separated by idle gaps, coins arriving after the chute opens, and a reset presented together with a coin show that the credit is held, that coins at 15 are ignored, and that reset wins. Both encodings run side by side against one behavioural credit model.

// File: rtl/coin_pkg.sv
package coin_pkg;

    localparam int unsigned LEVEL_W = 2;
    localparam int unsigned NUM_LEVELS = 1 << LEVEL_W;

    typedef enum logic [LEVEL_W-1:0] {
        CR_0  = 2'd0,
        CR_5  = 2'd1,
        CR_10 = 2'd2,
        CR_15 = 2'd3
    } credit_e;

    typedef struct packed {
        logic small_coin;
        logic large_coin;
    } coin_t;

    // Next credit level for one cycle of coin input; the top level absorbs all coins.
    function automatic credit_e credit_add(credit_e cur, coin_t coin);
        credit_e nxt;
        nxt = cur;
        if (cur != CR_15) begin
            if (coin.large_coin) begin
                nxt = (cur == CR_0) ? CR_10 : CR_15;
            end else if (coin.small_coin) begin
                nxt = credit_e'(cur + 2'd1);
            end
        end
        return nxt;
    endfunction

    function automatic logic [NUM_LEVELS-1:0] to_onehot(credit_e lvl);
        return NUM_LEVELS'(1) << lvl;
    endfunction

    function automatic credit_e from_onehot(logic [NUM_LEVELS-1:0] oh);
        credit_e lvl;
        lvl = CR_0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (oh[i]) lvl = credit_e'(i);
        end
        return lvl;
    endfunction

endpackage

// File: rtl/coin_step.sv
module coin_step
    import coin_pkg::*;
(
    input  credit_e cur_credit,
    input  coin_t   coin,
    output credit_e nxt_credit,
    output logic    nxt_full
);

    always_comb begin
        nxt_credit = credit_add(cur_credit, coin);
        nxt_full   = (nxt_credit == CR_15);
    end

endmodule

// File: rtl/credit_store.sv
module credit_store
    import coin_pkg::*;
#(
    parameter bit ONEHOT = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  credit_e nxt_credit,
    output credit_e cur_credit,
    output logic    full
);

    localparam int unsigned STATE_W = ONEHOT ? NUM_LEVELS : LEVEL_W;

    generate
        if (ONEHOT) begin : g_onehot
            logic [STATE_W-1:0] oh_q;

            always_ff @(posedge clk) begin
                if (rst) oh_q <= to_onehot(CR_0);
                else     oh_q <= to_onehot(nxt_credit);
            end

            always_comb begin
                cur_credit = from_onehot(oh_q);
                full       = oh_q[CR_15];
            end

            // R9: one-hot state keeps exactly one flop set
            a_r9_onehot_valid: assert property (@(posedge clk) disable iff (rst)
                $countones(oh_q) == 1);
        end else begin : g_binary
            logic [STATE_W-1:0] bin_q;

            always_ff @(posedge clk) begin
                if (rst) bin_q <= CR_0;
                else     bin_q <= nxt_credit;
            end

            always_comb begin
                cur_credit = credit_e'(bin_q);
                full       = bin_q[1] & bin_q[0];
            end
        end
    endgenerate

    // R1: reset lands in the zero-credit level
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> cur_credit == CR_0);

    // R7: the top level is held until reset
    a_r7_hold_full: assert property (@(posedge clk) disable iff (rst)
        cur_credit == CR_15 |=> cur_credit == CR_15);

endmodule

// File: rtl/release_reg.sv
module release_reg (
    input  logic clk,
    input  logic rst,
    input  logic nxt_full,
    output logic release_q
);

    always_ff @(posedge clk) begin
        if (rst) release_q <= 1'b0;
        else     release_q <= nxt_full;
    end

endmodule

// File: rtl/coin_gate.sv
module coin_gate
    import coin_pkg::*;
#(
    parameter bit ONEHOT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_i,
    input  logic dime_i,
    output logic release_o,
    output logic release_reg_o
);

    coin_t   coin;
    credit_e cur_credit;
    credit_e nxt_credit;
    logic    nxt_full;
    logic    full;

    always_comb begin
        coin.small_coin = nickel_i;
        coin.large_coin = dime_i;
    end

    coin_step i_step (
        .cur_credit (cur_credit),
        .coin       (coin),
        .nxt_credit (nxt_credit),
        .nxt_full   (nxt_full)
    );

    credit_store #(.ONEHOT(ONEHOT)) i_store (
        .clk        (clk),
        .rst        (rst),
        .nxt_credit (nxt_credit),
        .cur_credit (cur_credit),
        .full       (full)
    );

    release_reg i_rel (
        .clk       (clk),
        .rst       (rst),
        .nxt_full  (nxt_full),
        .release_q (release_reg_o)
    );

    assign release_o = full;

    // R5: no coin keeps the credit level
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!nickel_i && !dime_i) |=> $stable(cur_credit));

    // R2: a lone small coin from zero lands on 5
    a_r2_small_step: assert property (@(posedge clk) disable iff (rst)
        (cur_credit == CR_0 && nickel_i && !dime_i) |=> cur_credit == CR_5);

    // R4: a combined pulse from zero lands on 10
    a_r4_both_large: assert property (@(posedge clk) disable iff (rst)
        (cur_credit == CR_0 && nickel_i && dime_i) |=> cur_credit == CR_10);

    // R8: the registered release agrees with the state-decoded release
    a_r8_regs_agree: assert property (@(posedge clk) disable iff (rst)
        release_o == release_reg_o);

endmodule

// File: tb/test_coin_gate.sv
module test_coin_gate;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic rel_b, rel_reg_b, rel_h, rel_reg_h;

    int checks = 0;
    int fails = 0;
    int credit = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    coin_gate #(.ONEHOT(1'b0)) i_coin_gate (
        .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime),
        .release_o(rel_b), .release_reg_o(rel_reg_b));

    coin_gate #(.ONEHOT(1'b1)) i_coin_gate_oh (
        .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime),
        .release_o(rel_h), .release_reg_o(rel_reg_h));

    // Drive one cycle, advance the behavioural credit, compare all outputs.
    task automatic step(input logic r, input logic n, input logic d, input string tag);
        logic exp;
        @(negedge clk);
        rst = r; nickel = n; dime = d;
        @(posedge clk);
        if (r) credit = 0;
        else if (credit < 15) begin
            if (d) credit = credit + 10;
            else if (n) credit = credit + 5;
            if (credit > 15) credit = 15;
        end
        @(negedge clk);
        exp = (credit == 15);
        checks++;
        if (rel_b !== exp || rel_reg_b !== exp || rel_h !== exp || rel_reg_h !== exp) begin
            fails++;
            $display("FAIL %s: bin rel=%b reg=%b onehot rel=%b reg=%b expected %b (credit %0d)",
                     tag, rel_b, rel_reg_b, rel_h, rel_reg_h, exp, credit);
        end
        rst = 1'b0; nickel = 1'b0; dime = 1'b0;
    endtask

    initial begin
        step(1, 0, 0, "R1 reset");
        step(1, 0, 0, "R1 reset");
        step(0, 0, 0, "R5 idle at 0");
        step(0, 0, 0, "R5 idle at 0");
        // R2: three small coins
        step(0, 1, 0, "R2 0->5");
        step(0, 1, 0, "R2 5->10");
        step(0, 1, 0, "R2 10->15 R6 open");
        // R7: coins at 15 ignored
        step(0, 1, 0, "R7 small at 15");
        step(0, 0, 1, "R7 large at 15");
        step(0, 1, 1, "R7 both at 15");
        step(0, 0, 0, "R7 idle at 15");
        // R1: reset while open
        step(1, 0, 0, "R1 reset from 15");
        // R3: small then large
        step(0, 1, 0, "R3 0->5");
        step(0, 0, 1, "R3 5->15 R8");
        step(1, 0, 0, "R1 reset");
        // R3: large then small
        step(0, 0, 1, "R3 0->10 R6 closed");
        step(0, 1, 0, "R3 10->15");
        step(1, 0, 0, "R1 reset");
        // R3: two large coins saturate
        step(0, 0, 1, "R3 0->10");
        step(0, 0, 1, "R3 10->15 capped");
        step(0, 0, 0, "R7 hold");
        step(1, 0, 0, "R1 reset");
        // R5: gaps between coins
        step(0, 1, 0, "R5 0->5");
        step(0, 0, 0, "R5 hold 5");
        step(0, 0, 0, "R5 hold 5");
        step(0, 1, 0, "R5 5->10");
        step(0, 0, 0, "R5 hold 10");
        step(0, 1, 0, "R5 10->15");
        step(1, 0, 0, "R1 reset");
        // R4: combined pulse counts as large
        step(0, 1, 1, "R4 both 0->10");
        step(0, 1, 0, "R4 then small opens");
        step(1, 0, 0, "R1 reset");
        step(0, 1, 0, "R4 0->5");
        step(0, 1, 1, "R4 both 5->15");
        // R1: reset wins over a coin in the same cycle
        step(1, 0, 1, "R1 reset with coin");
        step(0, 1, 0, "R1 no carry 0->5");
        step(0, 1, 0, "R1 no carry 5->10 R9");
        step(1, 1, 0, "R1 reset with small");
        step(0, 0, 0, "R1 still 0");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule